// File: doc/BRIEF.md
# Serial Peripheral Master with Programmable Timing

This block sends and receives one character at a time over a four-wire serial peripheral bus. It drives one of four active-low select lines. A word is handed over through a valid/ready handshake together with the index of the select line to use. The block then performs a fixed sequence. It waits a programmable time with every select released. It asserts the chosen select. It waits a programmable lead time and then clocks out a character of 8 to 16 bits, most significant bit first. While it sends, it shifts in the returning bits from the peripheral. After the last edge it releases the select and holds a programmable gap before it accepts the next word.

The serial clock and all three waits are counted in system clocks. A divider sets the half-period. An optional divide-by-32 prescaler scales the divider and all three waits together, so one set of 8-bit fields covers both short and long timings. Each wait has a floor below which it cannot be programmed. The idle level of the serial clock and the edge on which data is captured are selectable. When the last bit is captured, a one-cycle done pulse appears and the received word is presented with it.

Top module: `spim_master`

## Requirements
- R1: During and after reset, every select line is high, `tx_ready` is 1, `rx_done` is 0 and `sclk` equals `cfg_cpol`.
- R2: A word is taken on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` then stays 0 until the gap after the character has elapsed, and all select lines are high whenever `tx_ready` is 1.
- R3: The scale S is 32 when `cfg_pre` is 1 and 1 otherwise. The selected line goes low max(`cfg_dly_cs`·S, 4) cycles after the accepting edge.
- R4: The first serial clock edge comes max(`cfg_dly_sck`·S, 2) + H cycles after the select goes low.
- R5: The half-period is H = max(`cfg_div`, 1)·S system clocks, so the serial clock period is 2H.
- R6: The select is released H cycles after the last serial clock edge. `tx_ready` returns max(`cfg_dly_gap`·S, 6) cycles after that release.
- R7: Only line `tx_sel` (bit index of `cs_n`) goes low, and at most one line is ever low.
- R8: The character length is L = 8 + min(`cfg_bits`, 8). The clock makes exactly 2L edges. MOSI carries `tx_data[L-1:0]`, most significant bit first.
- R9: The idle clock level is `cfg_cpol`. With `cfg_cpha`=0, bits are captured on odd-numbered edges (1st, 3rd, …) and MOSI changes on even-numbered ones. With `cfg_cpha`=1, this is reversed.
- R10: `rx_done` is a one-cycle pulse in the cycle the last capture edge appears on `sclk`. In that cycle `rx_data` holds the L captured bits, zero-extended, with the first received bit as bit L-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Capture-edge select |
| cfg_pre | input | 1 | Enables the divide-by-32 prescaler |
| cfg_div | input | 8 | Half-period divider (0 acts as 1) |
| cfg_bits | input | 4 | Extra bits beyond 8 (clamped to 8) |
| cfg_dly_cs | input | 8 | Wait before select assertion |
| cfg_dly_gap | input | 8 | Wait after select release |
| cfg_dly_sck | input | 8 | Wait from select to clock start |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Block idle, word accepted when valid |
| tx_data | input | 16 | Word to send, right-aligned |
| tx_sel | input | 2 | Select line index |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low select lines |
| rx_data | output | 16 | Received word, right-aligned |
| rx_done | output | 1 | One-cycle end-of-character pulse |

## Verification
The bench uses the default build: 16-bit maximum character, 8-bit divider and wait fields, and a prescaler shift of 5. With these values, every clamped and unclamped character length, all four clock modes, all four select lines and both wait floors and scaled waits fit in short runs. A behavioural peripheral model returns known words, so capture order and masking can be checked. The prescaler and the largest divider and wait values get their own transfers, which exercise the wide counters at their upper end.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LEAD,
    ST_XFER,
    ST_GAP
  } spim_state_e;
endpackage

// File: rtl/spim_timing.sv
// Converts divider and wait fields into cycle counts, applying prescaler and floors.
module spim_timing #(
  parameter int DIV_W    = 8,
  parameter int DLY_W    = 8,
  parameter int PRE_LOG2 = 5,
  parameter int CW       = 13,
  parameter int MIN_PRE  = 4,
  parameter int MIN_GAP  = 6,
  parameter int MIN_LEAD = 2
) (
  input  logic             cfg_pre,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [DLY_W-1:0] dly_cs,
  input  logic [DLY_W-1:0] dly_gap,
  input  logic [DLY_W-1:0] dly_sck,
  output logic [CW-1:0]    len_half,
  output logic [CW-1:0]    len_pre,
  output logic [CW-1:0]    len_gap,
  output logic [CW-1:0]    len_lead
);
  function automatic logic [CW-1:0] scaled(input logic [CW-1:0] base,
                                           input logic pre,
                                           input logic [CW-1:0] floor_v);
    logic [CW-1:0] v;
    v = pre ? (base << PRE_LOG2) : base;
    return (v < floor_v) ? floor_v : v;
  endfunction

  logic [CW-1:0] div_base;

  always_comb begin
    div_base = (cfg_div == '0) ? CW'(1) : CW'(cfg_div);
    len_half = scaled(div_base, cfg_pre, CW'(1));
    len_pre  = scaled(CW'(dly_cs), cfg_pre, CW'(MIN_PRE));
    len_gap  = scaled(CW'(dly_gap), cfg_pre, CW'(MIN_GAP));
    len_lead = scaled(CW'(dly_sck), cfg_pre, CW'(MIN_LEAD));
  end
endmodule

// File: rtl/spim_ctrl.sv
// Sequencer: pre-wait, lead, clocking, gap; produces edge events for the shifter.
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int LEN_W = 5,
  parameter int CW    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  input  logic [SEL_W-1:0] tx_sel,
  input  logic             cfg_cpha,
  input  logic [LEN_W-1:0] len,
  input  logic [CW-1:0]    len_half,
  input  logic [CW-1:0]    len_pre,
  input  logic [CW-1:0]    len_gap,
  input  logic [CW-1:0]    len_lead,
  output logic             tx_ready,
  output logic             cs_active,
  output logic [SEL_W-1:0] sel_q,
  output logic             phase,
  output logic             load,
  output logic             shift_en,
  output logic             sample_en,
  output logic             last_sample
);
  localparam int EW = LEN_W + 1;

  spim_state_e      state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [EW-1:0]    eidx_q, eidx_d;
  logic             phase_q, phase_d;
  logic [SEL_W-1:0] sel_d;
  logic [EW-1:0]    eidx_end, eidx_last;
  logic             cnt_zero, toggle, leading;

  always_comb begin
    eidx_end  = {len, 1'b0};
    eidx_last = cfg_cpha ? (eidx_end - EW'(1)) : (eidx_end - EW'(2));
    cnt_zero  = (cnt_q == '0);
    toggle    = (state_q == ST_XFER) && cnt_zero && (eidx_q != eidx_end);
    leading   = ~eidx_q[0];
    sample_en = toggle && (cfg_cpha ? !leading : leading);
    shift_en  = toggle && (cfg_cpha ? (leading && (eidx_q != '0)) : !leading);
    last_sample = sample_en && (eidx_q == eidx_last);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    eidx_d  = eidx_q;
    phase_d = phase_q;
    sel_d   = sel_q;
    load    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (tx_valid) begin
          state_d = ST_PRE;
          cnt_d   = len_pre - CW'(1);
          sel_d   = tx_sel;
          load    = 1'b1;
        end
      end
      ST_PRE: begin
        if (cnt_zero) begin
          state_d = ST_LEAD;
          cnt_d   = len_lead - CW'(1);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_LEAD: begin
        if (cnt_zero) begin
          state_d = ST_XFER;
          cnt_d   = len_half - CW'(1);
          eidx_d  = '0;
          phase_d = 1'b0;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_XFER: begin
        if (cnt_zero) begin
          if (eidx_q == eidx_end) begin
            state_d = ST_GAP;
            cnt_d   = len_gap - CW'(1);
          end else begin
            phase_d = ~phase_q;
            eidx_d  = eidx_q + EW'(1);
            cnt_d   = len_half - CW'(1);
          end
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_GAP: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - CW'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      eidx_q  <= '0;
      phase_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      eidx_q  <= eidx_d;
      phase_q <= phase_d;
      sel_q   <= sel_d;
    end
  end

  assign tx_ready  = (state_q == ST_IDLE);
  assign cs_active = (state_q == ST_LEAD) || (state_q == ST_XFER);
  assign phase     = phase_q;
endmodule

// File: rtl/spim_shifter.sv
// Transmit and receive shift registers, MSB first, variable length.
module spim_shifter #(
  parameter int MAX_W = 16,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MAX_W-1:0] load_data,
  input  logic [LEN_W-1:0] len,
  input  logic             shift_en,
  input  logic             sample_en,
  input  logic             last_sample,
  input  logic             miso,
  output logic             mosi,
  output logic [MAX_W-1:0] rx_data,
  output logic             rx_done
);
  logic [MAX_W-1:0] tx_q, tx_d, rs_q, rs_d, ro_q, ro_d, mask, rs_next;
  logic [LEN_W-1:0] pad;
  logic             done_d, done_q;

  always_comb begin
    pad     = LEN_W'(MAX_W) - len;
    mask    = {MAX_W{1'b1}} >> pad;
    rs_next = {rs_q[MAX_W-2:0], miso};
    tx_d    = tx_q;
    rs_d    = rs_q;
    ro_d    = ro_q;
    if (load)          tx_d = load_data << pad;
    else if (shift_en) tx_d = {tx_q[MAX_W-2:0], 1'b0};
    if (load)           rs_d = '0;
    else if (sample_en) rs_d = rs_next;
    if (last_sample) ro_d = rs_next & mask;
    done_d = last_sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rs_q   <= '0;
      ro_q   <= '0;
      done_q <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rs_q   <= rs_d;
      ro_q   <= ro_d;
      done_q <= done_d;
    end
  end

  assign mosi    = tx_q[MAX_W-1];
  assign rx_data = ro_q;
  assign rx_done = done_q;
endmodule

// File: rtl/spim_master.sv
module spim_master #(
  parameter int NCS      = 4,
  parameter int MAX_W    = 16,
  parameter int MIN_BITS = 8,
  parameter int DIV_W    = 8,
  parameter int DLY_W    = 8,
  parameter int PRE_LOG2 = 5,
  parameter int MIN_PRE  = 4,
  parameter int MIN_GAP  = 6,
  parameter int MIN_LEAD = 2,
  localparam int SEL_W   = $clog2(NCS),
  localparam int XB_MAX  = MAX_W - MIN_BITS,
  localparam int BITS_W  = $clog2(XB_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_pre,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [BITS_W-1:0] cfg_bits,
  input  logic [DLY_W-1:0]  cfg_dly_cs,
  input  logic [DLY_W-1:0]  cfg_dly_gap,
  input  logic [DLY_W-1:0]  cfg_dly_sck,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [MAX_W-1:0]  tx_data,
  input  logic [SEL_W-1:0]  tx_sel,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs_n,
  output logic [MAX_W-1:0]  rx_data,
  output logic              rx_done
);
  localparam int LEN_W = $clog2(MAX_W + 1);
  localparam int CW    = ((DIV_W > DLY_W) ? DIV_W : DLY_W) + PRE_LOG2;

  logic [1:0]       rst_sync;
  logic             rst_n_i;
  logic [LEN_W-1:0] len;
  logic [CW-1:0]    len_half, len_pre, len_gap, len_lead;
  logic             cs_active, phase, load, shift_en, sample_en, last_sample;
  logic [SEL_W-1:0] sel_q;

  // Reset asserts at once, releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  always_comb begin
    if (cfg_bits > BITS_W'(XB_MAX)) len = LEN_W'(MAX_W);
    else                            len = LEN_W'(MIN_BITS) + LEN_W'(cfg_bits);
  end

  spim_timing #(
    .DIV_W(DIV_W), .DLY_W(DLY_W), .PRE_LOG2(PRE_LOG2), .CW(CW),
    .MIN_PRE(MIN_PRE), .MIN_GAP(MIN_GAP), .MIN_LEAD(MIN_LEAD)
  ) u_timing (
    .cfg_pre (cfg_pre),
    .cfg_div (cfg_div),
    .dly_cs  (cfg_dly_cs),
    .dly_gap (cfg_dly_gap),
    .dly_sck (cfg_dly_sck),
    .len_half(len_half),
    .len_pre (len_pre),
    .len_gap (len_gap),
    .len_lead(len_lead)
  );

  spim_ctrl #(.SEL_W(SEL_W), .LEN_W(LEN_W), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .tx_valid   (tx_valid),
    .tx_sel     (tx_sel),
    .cfg_cpha   (cfg_cpha),
    .len        (len),
    .len_half   (len_half),
    .len_pre    (len_pre),
    .len_gap    (len_gap),
    .len_lead   (len_lead),
    .tx_ready   (tx_ready),
    .cs_active  (cs_active),
    .sel_q      (sel_q),
    .phase      (phase),
    .load       (load),
    .shift_en   (shift_en),
    .sample_en  (sample_en),
    .last_sample(last_sample)
  );

  spim_shifter #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .load       (load),
    .load_data  (tx_data),
    .len        (len),
    .shift_en   (shift_en),
    .sample_en  (sample_en),
    .last_sample(last_sample),
    .miso       (miso),
    .mosi       (mosi),
    .rx_data    (rx_data),
    .rx_done    (rx_done)
  );

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n[i] = ~(cs_active && (sel_q == SEL_W'(i)));
  end

  assign sclk = phase ^ cfg_cpol;
endmodule

// File: rtl/spim_master_chk.sv
module spim_master_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_cpol,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic [NCS-1:0] cs_n,
  input logic           sclk,
  input logic           rx_done
);
  assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (cs_n == {NCS{1'b1}}));

  assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (sclk == cfg_cpol));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  assert_done_framed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (cs_n != {NCS{1'b1}}));

  assert_accept_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (cs_n == {NCS{1'b1}}));
endmodule

bind spim_master spim_master_chk #(.NCS(NCS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_cpol(cfg_cpol),
  .tx_valid(tx_valid),
  .tx_ready(tx_ready),
  .cs_n    (cs_n),
  .sclk    (sclk),
  .rx_done (rx_done)
);

// File: tb/spim_master_tb.sv
module spim_master_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_cpol, cfg_cpha, cfg_pre;
  logic [7:0]  cfg_div, cfg_dly_cs, cfg_dly_gap, cfg_dly_sck;
  logic [3:0]  cfg_bits;
  logic        tx_valid, tx_ready, sclk, mosi, miso, rx_done;
  logic [15:0] tx_data, rx_data;
  logic [1:0]  tx_sel;
  logic [3:0]  cs_n;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  spim_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_pre(cfg_pre), .cfg_div(cfg_div), .cfg_bits(cfg_bits),
    .cfg_dly_cs(cfg_dly_cs), .cfg_dly_gap(cfg_dly_gap), .cfg_dly_sck(cfg_dly_sck),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_sel(tx_sel),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .rx_data(rx_data), .rx_done(rx_done)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic run_xfer(input int sel, input logic [15:0] d, input logic [15:0] s);
    int sc, h, dp, dl, dg, l, mask, last_smp;
    int k, k_fall, k_first, k_last, k_rise, k_rdy, toggles, bad_sp, sp_val, done_cnt, sbit;
    int mos;
    bit fall_seen, rise_seen;
    logic prev_sclk;
    sc   = cfg_pre ? 32 : 1;
    h    = max2(int'(cfg_div), 1) * sc;
    dp   = max2(int'(cfg_dly_cs) * sc, 4);
    dl   = max2(int'(cfg_dly_sck) * sc, 2);
    dg   = max2(int'(cfg_dly_gap) * sc, 6);
    l    = 8 + ((cfg_bits > 8) ? 8 : int'(cfg_bits));
    mask = (1 << l) - 1;
    last_smp = cfg_cpha ? (2*l - 1) : (2*l - 2);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = d; tx_sel = 2'(sel);
    @(negedge clk);
    tx_valid = 1'b0;
    k = 0; toggles = 0; bad_sp = 0; sp_val = 0; done_cnt = 0; mos = 0; sbit = 0;
    k_fall = -1; k_first = -1; k_last = -1; k_rise = -1; k_rdy = -1;
    fall_seen = 0; rise_seen = 0;
    prev_sclk = sclk;
    while (k < 20000) begin
      if (!fall_seen && cs_n != 4'hF) begin
        fall_seen = 1; k_fall = k;
        check_eq("R7", "selected line", int'(cs_n), int'(~(4'b1 << sel) & 4'hF));
        check_eq("R9", "clock idle at select", int'(sclk), int'(cfg_cpol));
        sbit = l - 1; miso = s[sbit];
      end
      if (sclk != prev_sclk) begin
        if (toggles == 0) k_first = k;
        else if (k - k_last != h) begin bad_sp++; sp_val = k - k_last; end
        k_last = k;
        if (cfg_cpha ? (toggles % 2 == 1) : (toggles % 2 == 0)) begin
          mos = (mos << 1) | int'(mosi);
          if (toggles == last_smp) begin
            check_eq("R10", "done on last capture", int'(rx_done), 1);
            check_eq("R10", "received word", int'(rx_data), int'(s) & mask);
          end
        end
        if ((cfg_cpha ? (toggles % 2 == 0 && toggles > 0) : (toggles % 2 == 1)) && sbit > 0) begin
          sbit--; miso = s[sbit];
        end
        toggles++;
      end
      if (rx_done) done_cnt++;
      if (fall_seen && !rise_seen && cs_n == 4'hF) begin rise_seen = 1; k_rise = k; end
      if (tx_ready) begin k_rdy = k; break; end
      prev_sclk = sclk;
      @(negedge clk);
      k++;
    end
    check_eq("R3", "select delay", k_fall, dp);
    check_eq("R4", "lead to first edge", k_first - k_fall, dl + h);
    check_eq("R5", "half-period", (bad_sp == 0) ? h : sp_val, h);
    check_eq("R8", "edge count", toggles, 2*l);
    check_eq("R8", "sent word", mos, int'(d) & mask);
    check_eq("R10", "done pulses", done_cnt, 1);
    check_eq("R6", "release after last edge", k_rise - k_last, h);
    check_eq("R6", "gap before ready", k_rdy - k_rise, dg);
    check_eq("R2", "ready after gap", int'(tx_ready), 1);
    check_eq("R9", "clock idle after", int'(sclk), int'(cfg_cpol));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int idx;
    rst_n = 1'b0; cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_pre = 1'b0; cfg_div = 8'd1;
    cfg_bits = 4'd0; cfg_dly_cs = 8'd0; cfg_dly_gap = 8'd0; cfg_dly_sck = 8'd0;
    tx_valid = 1'b0; tx_data = '0; tx_sel = '0; miso = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1", "select lines in reset", int'(cs_n), 15);
    check_eq("R1", "ready in reset", int'(tx_ready), 1);
    check_eq("R1", "done in reset", int'(rx_done), 0);
    check_eq("R1", "clock level in reset", int'(sclk), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1", "select lines after reset", int'(cs_n), 15);
    check_eq("R1", "ready after reset", int'(tx_ready), 1);

    idx = 0;
    for (int cp = 0; cp < 2; cp++) begin
      for (int ph = 0; ph < 2; ph++) begin
        for (int b = 0; b < 4; b++) begin
          cfg_cpol = cp[0]; cfg_cpha = ph[0]; cfg_pre = 1'b0;
          cfg_bits = (b == 0) ? 4'd0 : (b == 1) ? 4'd5 : (b == 2) ? 4'd8 : 4'd12;
          cfg_div = 8'(b % 3);
          cfg_dly_cs = 8'(idx % 6); cfg_dly_gap = 8'((idx * 3) % 9); cfg_dly_sck = 8'((idx * 2) % 5);
          run_xfer(idx % 4, 16'hA5C3 ^ 16'(idx * 16'h1357), 16'h3C96 + 16'(idx * 7));
          idx++;
        end
      end
    end

    cfg_pre = 1'b1; cfg_div = 8'd1; cfg_bits = 4'd0; cfg_cpol = 1'b0; cfg_cpha = 1'b1;
    cfg_dly_cs = 8'd1; cfg_dly_gap = 8'd0; cfg_dly_sck = 8'd1;
    run_xfer(2, 16'h00B7, 16'h005A);
    cfg_div = 8'd0; cfg_bits = 4'd8; cfg_cpha = 1'b0; cfg_dly_cs = 8'd0; cfg_dly_sck = 8'd0;
    cfg_dly_gap = 8'd1;
    run_xfer(1, 16'hF00D, 16'h8001);
    cfg_pre = 1'b0; cfg_div = 8'd255; cfg_bits = 4'd0; cfg_cpol = 1'b1; cfg_cpha = 1'b1;
    cfg_dly_cs = 8'd255; cfg_dly_gap = 8'd255; cfg_dly_sck = 8'd255;
    run_xfer(3, 16'h1234, 16'h00FF);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule